// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the 24-bit effective address of one memory operand in a flat 16 MB space, where no bank or segment register exists. It takes a one-hot-free mode code together with the raw operand bytes, the address of the next instruction, the relocatable direct-page base, the two index registers, the current operand width and the extended status word. The result and the post-access values of both pointer registers appear one clock after the request.

Three address forms are covered. A direct-page reference adds a one-byte offset to a 24-bit base, so the 256-byte window may sit anywhere. A relative reference adds a signed displacement to the address of the following instruction. A persistent flag selects an 8-bit or a full 24-bit displacement, and the same rule applies to branches and to the relative subroutine jump. A pointer reference uses X or Y directly as the address and may then step that register up or down by the operand size, in the manner of string moves. All sums wrap modulo 2^24. Opcode decode and the memory access sequence belong to neighbouring blocks.

Top module: `eagu_top`

## Requirements
- R1: While rst_n is low and until the first accepted request, ea_valid, ea, x_out and y_out are all zero.
- R2: Mode code 0 (direct page) yields ea = dp_base + opnd[7:0]; opnd[23:8] has no effect.
- R3: Mode code 1 (relative) with long_rel = 0 yields ea = pc_next + the sign extension of opnd[7:0]; opnd[23:8] has no effect.
- R4: Mode code 1 with long_rel = 1 yields ea = pc_next + opnd[23:0], the operand read as a signed 24-bit value.
- R5: Mode code 2 (X pointer) yields ea equal to x_in before any stepping.
- R6: Mode code 3 (Y pointer) yields ea equal to y_in before any stepping.
- R7: When the pointer in use has its enable bit set (status[19] for X, status[18] for Y), it is stepped by width_code + 1 bytes (code 0 byte, 1 two bytes, 2 three bytes, 3 four bytes).
- R8: The direction bit (status[17] for X, status[16] for Y) steps up when clear and down when set.
- R9: A register not addressed by the request, or one whose enable bit is clear, is returned unchanged on x_out / y_out.
- R10: Results appear the cycle after a request with ea_valid high for that one cycle; without a request ea_valid is low and ea, x_out, y_out hold.
- R11: Every address sum and pointer step wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; inputs sampled when high |
| req_mode | input | 2 | 0 direct page, 1 relative, 2 X pointer, 3 Y pointer |
| opnd | input | 24 | Operand bytes, first byte in bits 7:0 |
| pc_next | input | 24 | Address of the instruction after the current one |
| dp_base | input | 24 | Direct-page base register |
| x_in | input | 24 | X register value |
| y_in | input | 24 | Y register value |
| width_code | input | 2 | Operand width: 0..3 for 1..4 bytes |
| long_rel | input | 1 | Selects 24-bit relative displacement |
| status | input | 24 | Extended status word; bits 19..16 control stepping |
| ea_valid | output | 1 | Result strobe |
| ea | output | 24 | Effective address |
| x_out | output | 24 | X after the access |
| y_out | output | 24 | Y after the access |

## Verification
In a pointer request the address output and the stepped register are produced in the same cycle from the same source, so a slip that feeds the stepped value into ea, or the old value into x_out, shows up at once. The bench provokes this with X and Y requests at every width and both directions, including a decrement from zero, and judges ea against the pre-step register and the pointer output against the independently computed step. Requests that must leave a register alone set all four step bits to expose any leakage.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
   typedef enum logic [1:0] {
      EA_DIRECT   = 2'd0,
      EA_RELATIVE = 2'd1,
      EA_XPTR     = 2'd2,
      EA_YPTR     = 2'd3
   } ea_mode_e;

   localparam int STAT_W       = 24;
   localparam int WCODE_W      = 2;
   localparam int XSTEP_EN_BIT = 19;
   localparam int XSTEP_DN_BIT = 17;
   localparam int NUM_PTR      = 2;
endpackage

// File: rtl/eagu_dp_calc.sv
module eagu_dp_calc #(
   parameter int ADDR_W = 24,
   parameter int OFFS_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFFS_W-1:0] offs,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = ADDR_W - OFFS_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("eagu_dp_calc: offset must be narrower than address");
   end

   always_comb begin
      addr = base + {{PAD_W{1'b0}}, offs};
   end
endmodule

// File: rtl/eagu_rel_calc.sv
module eagu_rel_calc #(
   parameter int ADDR_W  = 24,
   parameter int SHORT_W = 8
) (
   input  logic [ADDR_W-1:0] next_pc,
   input  logic [ADDR_W-1:0] disp_raw,
   input  logic              long_sel,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] short_disp;
   logic [ADDR_W-1:0] disp;

   if (SHORT_W < ADDR_W) begin : g_sext
      localparam int EXT_W = ADDR_W - SHORT_W;
      always_comb begin
         short_disp = {{EXT_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
      end
   end else begin : g_full
      always_comb begin
         short_disp = disp_raw;
      end
   end

   always_comb begin
      disp = long_sel ? disp_raw : short_disp;
      addr = next_pc + disp;
   end
endmodule

// File: rtl/eagu_ptr_step.sv
module eagu_ptr_step #(
   parameter int ADDR_W  = 24,
   parameter int WCODE_W = 2
) (
   input  logic [ADDR_W-1:0]  ptr,
   input  logic               active,
   input  logic               step_en,
   input  logic               step_dn,
   input  logic [WCODE_W-1:0] wcode,
   output logic [ADDR_W-1:0]  ptr_nxt
);
   localparam int PAD_W = ADDR_W - WCODE_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("eagu_ptr_step: width code too wide");
   end

   logic [ADDR_W-1:0] amount;

   always_comb begin
      amount = {{PAD_W{1'b0}}, wcode} + {{(ADDR_W-1){1'b0}}, 1'b1};
      if (active && step_en) begin
         ptr_nxt = step_dn ? (ptr - amount) : (ptr + amount);
      end else begin
         ptr_nxt = ptr;
      end
   end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
   import eagu_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int OFFS_W  = 8,
   parameter int SHORT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_mode,
   input  logic [ADDR_W-1:0]   opnd,
   input  logic [ADDR_W-1:0]   pc_next,
   input  logic [ADDR_W-1:0]   dp_base,
   input  logic [ADDR_W-1:0]   x_in,
   input  logic [ADDR_W-1:0]   y_in,
   input  logic [WCODE_W-1:0]  width_code,
   input  logic                long_rel,
   input  logic [STAT_W-1:0]   status,
   output logic                ea_valid,
   output logic [ADDR_W-1:0]   ea,
   output logic [ADDR_W-1:0]   x_out,
   output logic [ADDR_W-1:0]   y_out
);
   if (OFFS_W > ADDR_W || SHORT_W > ADDR_W) begin : g_bad_cfg
      $error("eagu_top: offset widths exceed address width");
   end
   if (XSTEP_EN_BIT >= STAT_W) begin : g_bad_stat
      $error("eagu_top: status word too narrow for step bits");
   end

   ea_mode_e          mode;
   logic [ADDR_W-1:0] dp_addr;
   logic [ADDR_W-1:0] rel_addr;
   logic [ADDR_W-1:0] ea_nxt;
   logic [ADDR_W-1:0] ptr_in  [NUM_PTR];
   logic [ADDR_W-1:0] ptr_nxt [NUM_PTR];
   logic              ptr_act [NUM_PTR];

   assign mode      = ea_mode_e'(req_mode);
   assign ptr_in[0] = x_in;
   assign ptr_in[1] = y_in;
   assign ptr_act[0] = (mode == EA_XPTR);
   assign ptr_act[1] = (mode == EA_YPTR);

   eagu_dp_calc #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_dp (
      .base (dp_base),
      .offs (opnd[OFFS_W-1:0]),
      .addr (dp_addr)
   );

   eagu_rel_calc #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) i_rel (
      .next_pc  (pc_next),
      .disp_raw (opnd),
      .long_sel (long_rel),
      .addr     (rel_addr)
   );

   for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
      eagu_ptr_step #(.ADDR_W(ADDR_W), .WCODE_W(WCODE_W)) i_step (
         .ptr     (ptr_in[p]),
         .active  (ptr_act[p]),
         .step_en (status[XSTEP_EN_BIT - p]),
         .step_dn (status[XSTEP_DN_BIT - p]),
         .wcode   (width_code),
         .ptr_nxt (ptr_nxt[p])
      );
   end

   always_comb begin
      unique case (mode)
         EA_DIRECT:   ea_nxt = dp_addr;
         EA_RELATIVE: ea_nxt = rel_addr;
         EA_XPTR:     ea_nxt = x_in;
         EA_YPTR:     ea_nxt = y_in;
         default:     ea_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_valid <= 1'b0;
         ea       <= '0;
         x_out    <= '0;
         y_out    <= '0;
      end else begin
         ea_valid <= req_valid;
         if (req_valid) begin
            ea    <= ea_nxt;
            x_out <= ptr_nxt[0];
            y_out <= ptr_nxt[1];
         end
      end
   end
endmodule

// File: rtl/eagu_chk.sv
module eagu_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_mode,
   input logic [ADDR_W-1:0] x_in,
   input logic [ADDR_W-1:0] y_in,
   input logic [1:0]        width_code,
   input logic [23:0]       status,
   input logic              ea_valid,
   input logic [ADDR_W-1:0] ea,
   input logic [ADDR_W-1:0] x_out,
   input logic [ADDR_W-1:0] y_out
);
   assert_strobe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ea_valid);

   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!ea_valid && $stable(ea) && $stable(x_out) && $stable(y_out)));

   assert_xptr_prestep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd2) |=> (ea == $past(x_in)));

   assert_yptr_prestep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd3) |=> (ea == $past(y_in)));

   assert_untouched_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode[1] == 1'b0) |=> (x_out == $past(x_in) && y_out == $past(y_in)));

   assert_x_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'd2 && status[19] && !status[17])
      |=> (x_out == $past(x_in) + {{(ADDR_W-2){1'b0}}, $past(width_code)} + 1'b1));
endmodule

bind eagu_top eagu_chk #(.ADDR_W(ADDR_W)) i_eagu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_mode   (req_mode),
   .x_in       (x_in),
   .y_in       (y_in),
   .width_code (width_code),
   .status     (status),
   .ea_valid   (ea_valid),
   .ea         (ea),
   .x_out      (x_out),
   .y_out      (y_out)
);

// File: tb/test_eagu_top.sv
module test_eagu_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [23:0] opnd = '0;
   logic [23:0] pc_next = '0;
   logic [23:0] dp_base = '0;
   logic [23:0] x_in = '0;
   logic [23:0] y_in = '0;
   logic [1:0]  width_code = '0;
   logic        long_rel = 1'b0;
   logic [23:0] status = '0;
   logic        ea_valid;
   logic [23:0] ea;
   logic [23:0] x_out;
   logic [23:0] y_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eagu_top i_eagu_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .opnd(opnd), .pc_next(pc_next), .dp_base(dp_base), .x_in(x_in), .y_in(y_in),
      .width_code(width_code), .long_rel(long_rel), .status(status),
      .ea_valid(ea_valid), .ea(ea), .x_out(x_out), .y_out(y_out)
   );

   task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive one request at a falling edge, retire it at the next falling edge
   task automatic issue(input logic [1:0] m, input logic [23:0] op, input logic [1:0] wc,
                        input logic lr, input logic [23:0] st);
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; opnd = op; width_code = wc; long_rel = lr; status = st;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 strobe", {23'd0, ea_valid}, 24'd1);
   endtask

   task automatic t_reset;
      check("R1 ea_valid", {23'd0, ea_valid}, 24'd0);
      check("R1 ea", ea, 24'd0);
      check("R1 x_out", x_out, 24'd0);
      check("R1 y_out", y_out, 24'd0);
   endtask

   task automatic t_direct;
      dp_base = 24'h123400;
      issue(2'd0, 24'hABCD56, 2'd0, 1'b0, 24'h0);
      check("R2 direct page", ea, 24'h123456);
      dp_base = 24'hFFFFF0;
      issue(2'd0, 24'h000020, 2'd0, 1'b0, 24'h0);
      check("R11 direct wrap", ea, 24'h000010);
   endtask

   task automatic t_relative;
      pc_next = 24'h001000;
      issue(2'd1, 24'h0000F0, 2'd0, 1'b0, 24'h0);
      check("R3 short backward", ea, 24'h000FF0);
      issue(2'd1, 24'hABCD05, 2'd0, 1'b0, 24'h0);
      check("R3 short upper bytes ignored", ea, 24'h001005);
      pc_next = 24'h400000;
      issue(2'd1, 24'hC00000, 2'd0, 1'b1, 24'h0);
      check("R4 long backward", ea, 24'h000000);
      pc_next = 24'h001000;
      issue(2'd1, 24'h0000F0, 2'd0, 1'b1, 24'h0);
      check("R4 long positive", ea, 24'h0010F0);
      pc_next = 24'hFFFFFE;
      issue(2'd1, 24'h000004, 2'd0, 1'b1, 24'h0);
      check("R11 relative wrap", ea, 24'h000002);
   endtask

   task automatic t_pointers;
      x_in = 24'h021000; y_in = 24'hE24000;
      issue(2'd2, 24'h0, 2'd3, 1'b0, 24'h0F0000 & ~24'h020000 & ~24'h010000 | 24'h080000);
      check("R5 x address", ea, 24'h021000);
      check("R7 x step four", x_out, 24'h021004);
      check("R9 y untouched", y_out, 24'hE24000);
      x_in = 24'h000000;
      issue(2'd2, 24'h0, 2'd0, 1'b0, 24'h0A0000);
      check("R8 x down wrap R11", x_out, 24'hFFFFFF);
      issue(2'd3, 24'h0, 2'd1, 1'b0, 24'h040000);
      check("R6 y address", ea, 24'hE24000);
      check("R7 y step two", y_out, 24'hE24002);
      check("R9 x untouched", x_out, 24'h000000);
      y_in = 24'h000010;
      issue(2'd3, 24'h0, 2'd2, 1'b0, 24'h050000);
      check("R8 y step down three", y_out, 24'h00000D);
   endtask

   task automatic t_no_step;
      x_in = 24'h300000; y_in = 24'h400000;
      issue(2'd2, 24'h0, 2'd3, 1'b0, 24'h070000);
      check("R9 x enable clear", x_out, 24'h300000);
      check("R9 y not addressed", y_out, 24'h400000);
      dp_base = 24'h500000;
      issue(2'd0, 24'h000001, 2'd3, 1'b0, 24'h0F0000);
      check("R9 direct keeps x", x_out, 24'h300000);
      check("R9 direct keeps y", y_out, 24'h400000);
   endtask

   task automatic t_hold;
      dp_base = 24'h777700; x_in = 24'h111111;
      issue(2'd0, 24'h000011, 2'd0, 1'b0, 24'h0);
      dp_base = 24'h000000; x_in = 24'h222222;
      @(negedge clk);
      check("R10 idle strobe low", {23'd0, ea_valid}, 24'd0);
      check("R10 idle ea held", ea, 24'h777711);
      check("R10 idle x held", x_out, 24'h111111);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_direct;
      t_relative;
      t_pointers;
      t_no_step;
      t_hold;
      finish_run;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run;
   end
endmodule